// File: doc/BRIEF.md
# Macroblock-Paced Decoder Output Sequencer

This block feeds a downstream macroblock decoder over an 8-bit byte bus. Every byte carries a 4-bit mode label that says what the byte is. A free-running output strobe at half the system clock qualifies the bytes, and each byte is held for two system clocks. An upstream parser hands over macroblock records through a valid/ready handshake. Each record holds a group-of-blocks (GOB) number, a macroblock number, control-decision bits and an optional quantizer byte.

Each record opens a slot. The slot always begins with the control-decisions byte, then the GOB number, then the macroblock number, and then the quantizer byte if the record has one. Wait codes then pad the slot until the minimum slot length has elapsed. The block keeps track of the position it expects next. When a record arrives ahead of that position, the block first sends one fixed (repeat-previous) macroblock for every skipped position, in order and across picture boundaries. Only then does it take the record.

Wait periods are not wasted. A side-information port can place a tagged byte on the bus during any wait byte. A separate 3-bit tag names the kind of side information.

Top module: `mbout_seq`

## Requirements
- R1: `out_clk` toggles on every system clock edge after reset, so it runs at half the system clock, and each output byte is held for one full `out_clk` period.
- R2: `out_mode` labels every byte with one of these codes: 0000 GOB number, 0001 macroblock number, 0010 control decisions, 0011 quantizer, 1111 wait. Codes 0100 to 1001 are reserved for motion vectors, coded block pattern, sub-block, zero run and coefficient. Codes 1010 to 1110 are never used.
- R3: A slot sends its bytes in this order: control decisions, GOB number, macroblock number, then the quantizer byte (mode 0011) only if the record had `rec_has_quant` set. Wait bytes follow.
- R4: Two control-decisions bytes are never loaded less than `SLOT_CLKS` system clocks apart (default 2048). Every non-slot byte is mode 1111.
- R5: For an accepted record, the control byte is `{cif_mode, rec_ctrl[6:0]}`. Bit 0 marks a fixed macroblock, bit 1 inter mode, bit 2 loop filter, bit 3 motion compensation, and bit 7 carries CIF.
- R6: A fixed macroblock has control byte `{cif_mode, 7'h01}`, meaning bit 0 is set and intra mode is used. It carries the GOB and macroblock numbers of the gap position, has no quantizer byte, and occupies a full slot.
- R7: If a record's position is not the next expected one, fixed macroblocks are emitted for every position in between, in order, and the sequence may wrap through end of picture.
- R8: In CIF mode (`cif_mode`=1), the position advances through macroblocks 1..33, then GOB+1 over 1..12, then wraps to 1. In QCIF mode, GOBs step 1, 3, 5 and then wrap to 1.
- R9: Reset gives `out_mode`=1111, `out_tag`=111 and `out_data`=0, with the position set to GOB 12 macroblock 33. As a result, a first record at GOB 1 macroblock 1 is taken with no fill.
- R10: On a wait byte with `side_valid` high, the block sends `side_data` with `out_tag`=`side_tag` and asserts `side_ready`. The codes are 000 temporal ref, 001 group spare, 010 picture spare, 011 picture type and 100 quantizer. Every primary byte and every empty wait byte carries tag 111. Side data is never taken on a primary byte.
- R11: `rec_ready` is high only in the clock where a slot opens with the record at the expected position. During fill slots the record stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cif_mode | input | 1 | 1 = CIF numbering, 0 = QCIF numbering |
| rec_valid | input | 1 | Upstream record valid |
| rec_ready | output | 1 | Record accepted this clock |
| rec_gob | input | 4 | Record GOB number |
| rec_mb | input | 6 | Record macroblock number |
| rec_ctrl | input | 7 | Record control-decision bits 6..0 |
| rec_has_quant | input | 1 | Record carries a quantizer byte |
| rec_quant | input | 8 | Quantizer value |
| side_valid | input | 1 | Side-information byte offered |
| side_ready | output | 1 | Side byte taken this clock |
| side_tag | input | 3 | Side-information kind |
| side_data | input | 8 | Side-information byte |
| out_clk | output | 1 | Continuous byte strobe, clk/2 |
| out_data | output | 8 | Output byte |
| out_mode | output | 4 | Byte label |
| out_tag | output | 3 | Side-information tag, 111 for primary |

## Verification
The bench covers four behaviours. The first is the first record after reset: a wrong reset position would insert hundreds of spurious fixed slots. The second is the wrap of fills through end of picture in both CIF and QCIF: a wrong step rule would emit an even QCIF GOB or a GOB 13, or would never reach the record. The third is a record held through a long run of fill slots: early acceptance would drop the fills, and late acceptance would duplicate positions. The fourth is side data offered while primary bytes are pending: a design that takes it there would corrupt the GOB or macroblock byte, or would lose a side byte. A reference model in the bench predicts the outputs and both ready signals on every clock.

// File: rtl/mbout_pkg.sv
package mbout_pkg;
  // byte labels on the mode bus
  localparam logic [3:0] MODE_GOB   = 4'h0;
  localparam logic [3:0] MODE_MBNUM = 4'h1;
  localparam logic [3:0] MODE_CTRL  = 4'h2;
  localparam logic [3:0] MODE_QUANT = 4'h3;
  localparam logic [3:0] MODE_WAIT  = 4'hF;
  // tag meaning "bus holds primary data"
  localparam logic [2:0] TAG_PRIMARY = 3'd7;
  // control bits of a generated repeat macroblock: fixed, intra
  localparam logic [6:0] CTRL_FIXED = 7'h01;
endpackage

// File: rtl/mbout_pos_step.sv
module mbout_pos_step #(
  parameter int GOB_W     = 4,
  parameter int MB_W      = 6,
  parameter int CIF_GOBS  = 12,
  parameter int QCIF_LAST = 5,
  parameter int MBS       = 33
) (
  input  logic             cif,
  input  logic [GOB_W-1:0] cur_gob,
  input  logic [MB_W-1:0]  cur_mb,
  output logic [GOB_W-1:0] nxt_gob,
  output logic [MB_W-1:0]  nxt_mb
);
  always_comb begin
    nxt_gob = cur_gob;
    nxt_mb  = cur_mb + 1'b1;
    if (cur_mb >= MB_W'(MBS)) begin
      nxt_mb = MB_W'(1);
      if (cif) begin
        nxt_gob = (cur_gob >= GOB_W'(CIF_GOBS)) ? GOB_W'(1) : cur_gob + 1'b1;
      end else begin
        nxt_gob = (cur_gob >= GOB_W'(QCIF_LAST)) ? GOB_W'(1) : cur_gob + GOB_W'(2);
      end
    end
  end
endmodule

// File: rtl/mbout_strobe_timer.sv
module mbout_strobe_timer #(
  parameter int SLOT_TICKS = 1024,
  localparam int CNT_W     = $clog2(SLOT_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_go,
  output logic             tick,
  output logic             strobe,
  output logic             slot_open,
  output logic             active,
  output logic [CNT_W-1:0] idx
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_TICKS - 1);

  logic             phase_q, phase_d;
  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = ~phase_q;
    act_d   = act_q;
    cnt_d   = cnt_q;
    if (phase_q) begin
      if (slot_go) begin
        act_d = 1'b1;
        cnt_d = '0;
      end else if (act_q) begin
        if (cnt_q == LAST) act_d = 1'b0;
        else               cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      act_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      act_q   <= act_d;
      cnt_q   <= cnt_d;
    end
  end

  assign tick      = phase_q;
  assign strobe    = phase_q;
  assign slot_open = !act_q || (cnt_q == LAST);
  assign active    = act_q;
  assign idx       = cnt_q;

  // R1
  strobe_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (strobe != $past(strobe)));
endmodule

// File: rtl/mbout_seq.sv
module mbout_seq
  import mbout_pkg::*;
#(
  parameter int SLOT_CLKS = 2048,
  parameter int GOB_W     = 4,
  parameter int MB_W      = 6,
  parameter int CIF_GOBS  = 12,
  parameter int QCIF_LAST = 5,
  parameter int MBS       = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cif_mode,
  input  logic             rec_valid,
  output logic             rec_ready,
  input  logic [GOB_W-1:0] rec_gob,
  input  logic [MB_W-1:0]  rec_mb,
  input  logic [6:0]       rec_ctrl,
  input  logic             rec_has_quant,
  input  logic [7:0]       rec_quant,
  input  logic             side_valid,
  output logic             side_ready,
  input  logic [2:0]       side_tag,
  input  logic [7:0]       side_data,
  output logic             out_clk,
  output logic [7:0]       out_data,
  output logic [3:0]       out_mode,
  output logic [2:0]       out_tag
);
  localparam int SLOT_TICKS = SLOT_CLKS / 2;
  localparam int CNT_W      = $clog2(SLOT_TICKS);
  localparam int GAP_W      = $clog2(SLOT_CLKS + 1);

  logic             tick, slot_open, active, go, hit, prim;
  logic [CNT_W-1:0] idx;
  logic [GOB_W-1:0] gob_q, gob_d, nxt_gob;
  logic [MB_W-1:0]  mb_q, mb_d, nxt_mb;
  logic             hasq_q, hasq_d;
  logic [7:0]       quant_q, quant_d;
  logic [7:0]       data_q, data_d;
  logic [3:0]       mode_q, mode_d;
  logic [2:0]       tag_q, tag_d;

  mbout_strobe_timer #(.SLOT_TICKS(SLOT_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .slot_go(go), .tick(tick), .strobe(out_clk),
    .slot_open(slot_open), .active(active), .idx(idx));

  mbout_pos_step #(.GOB_W(GOB_W), .MB_W(MB_W), .CIF_GOBS(CIF_GOBS),
                   .QCIF_LAST(QCIF_LAST), .MBS(MBS)) u_step (
    .cif(cif_mode), .cur_gob(gob_q), .cur_mb(mb_q), .nxt_gob(nxt_gob), .nxt_mb(nxt_mb));

  assign go         = tick && slot_open && rec_valid;
  assign hit        = (rec_gob == nxt_gob) && (rec_mb == nxt_mb);
  assign rec_ready  = go && hit;
  assign prim       = active && ((idx == CNT_W'(0)) || (idx == CNT_W'(1)) ||
                                 ((idx == CNT_W'(2)) && hasq_q));
  assign side_ready = tick && side_valid && !go && !prim;

  always_comb begin
    gob_d   = gob_q;
    mb_d    = mb_q;
    hasq_d  = hasq_q;
    quant_d = quant_q;
    data_d  = data_q;
    mode_d  = mode_q;
    tag_d   = tag_q;
    if (tick) begin
      if (go) begin
        gob_d   = nxt_gob;
        mb_d    = nxt_mb;
        hasq_d  = hit && rec_has_quant;
        quant_d = rec_quant;
        mode_d  = MODE_CTRL;
        tag_d   = TAG_PRIMARY;
        data_d  = hit ? {cif_mode, rec_ctrl} : {cif_mode, CTRL_FIXED};
      end else if (prim) begin
        tag_d = TAG_PRIMARY;
        if (idx == CNT_W'(0)) begin
          mode_d = MODE_GOB;
          data_d = 8'(gob_q);
        end else if (idx == CNT_W'(1)) begin
          mode_d = MODE_MBNUM;
          data_d = 8'(mb_q);
        end else begin
          mode_d = MODE_QUANT;
          data_d = quant_q;
        end
      end else if (side_valid) begin
        mode_d = MODE_WAIT;
        tag_d  = side_tag;
        data_d = side_data;
      end else begin
        mode_d = MODE_WAIT;
        tag_d  = TAG_PRIMARY;
        data_d = 8'h00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gob_q   <= GOB_W'(CIF_GOBS);
      mb_q    <= MB_W'(MBS);
      hasq_q  <= 1'b0;
      quant_q <= 8'h00;
      data_q  <= 8'h00;
      mode_q  <= MODE_WAIT;
      tag_q   <= TAG_PRIMARY;
    end else begin
      gob_q   <= gob_d;
      mb_q    <= mb_d;
      hasq_q  <= hasq_d;
      quant_q <= quant_d;
      data_q  <= data_d;
      mode_q  <= mode_d;
      tag_q   <= tag_d;
    end
  end

  assign out_data = data_q;
  assign out_mode = mode_q;
  assign out_tag  = tag_q;

  // checker state: clocks since the last control byte was loaded
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  gap_q <= GAP_W'(SLOT_CLKS);
    else if (!out_clk && out_mode == MODE_CTRL)  gap_q <= GAP_W'(1);
    else if (gap_q < GAP_W'(SLOT_CLKS))          gap_q <= gap_q + 1'b1;
  end

  // R4
  slot_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !out_clk && out_mode == MODE_CTRL) |-> (gap_q >= GAP_W'(SLOT_CLKS)));

  // R3
  gob_after_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !out_clk && out_mode == MODE_GOB) |-> ($past(out_mode, 2) == MODE_CTRL));

  // R8
  gob_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_clk && out_mode == MODE_GOB) |->
      (cif_mode ? (out_data >= 8'd1 && out_data <= 8'(CIF_GOBS))
                : (out_data == 8'd1 || out_data == 8'd3 || out_data == 8'd5)));

  // R11
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_ready |-> rec_valid);

  // R10
  side_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    side_ready |=> (out_mode == MODE_WAIT && out_tag == $past(side_tag) &&
                    out_data == $past(side_data)));
endmodule

// File: tb/mbout_seq_bench.sv
`timescale 1ns/100ps
module mbout_seq_bench;
  localparam int BSLOT  = 64;
  localparam int SLOT_T = BSLOT / 2;

  logic clk, rst_n, cif_mode;
  logic rec_valid, rec_ready, rec_has_quant;
  logic [3:0] rec_gob;
  logic [5:0] rec_mb;
  logic [6:0] rec_ctrl;
  logic [7:0] rec_quant;
  logic side_valid, side_ready;
  logic [2:0] side_tag;
  logic [7:0] side_data;
  logic out_clk;
  logic [7:0] out_data;
  logic [3:0] out_mode;
  logic [2:0] out_tag;

  mbout_seq #(.SLOT_CLKS(BSLOT)) u_mbout_seq (
    .clk(clk), .rst_n(rst_n), .cif_mode(cif_mode), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_gob(rec_gob), .rec_mb(rec_mb), .rec_ctrl(rec_ctrl),
    .rec_has_quant(rec_has_quant), .rec_quant(rec_quant), .side_valid(side_valid),
    .side_ready(side_ready), .side_tag(side_tag), .side_data(side_data),
    .out_clk(out_clk), .out_data(out_data), .out_mode(out_mode), .out_tag(out_tag));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_phase, m_busy, m_loaded;
  int m_ticks, pg, pm;
  logic [11:0] mq[$];
  logic [7:0] e_data;
  logic [3:0] e_mode;
  logic [2:0] e_tag;

  function automatic void succ(input int g, input int m, input bit c,
                               output int ng, output int nm);
    ng = g; nm = m + 1;
    if (m >= 33) begin
      nm = 1;
      if (c) ng = (g >= 12) ? 1 : g + 1;
      else   ng = (g >= 5) ? 1 : g + 2;
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_busy = 0; m_ticks = 0; m_loaded = 0;
      pg = 12; pm = 33; mq.delete();
      e_data = 8'h00; e_mode = 4'hF; e_tag = 3'd7;
    end else begin
      int ng, nm;
      bit tk, open, hit;
      tk = m_phase; m_phase = !m_phase; m_loaded = tk;
      if (tk) begin
        open = !m_busy || (m_ticks == SLOT_T - 1);
        if (open && rec_valid) begin
          succ(pg, pm, cif_mode, ng, nm);
          hit = (int'(rec_gob) == ng) && (int'(rec_mb) == nm);
          pg = ng; pm = nm; mq.delete();
          e_mode = 4'h2; e_tag = 3'd7;
          e_data = hit ? {cif_mode, rec_ctrl} : {cif_mode, 7'h01};
          mq.push_back({4'h0, 8'(ng)});
          mq.push_back({4'h1, 8'(nm)});
          if (hit && rec_has_quant) mq.push_back({4'h3, rec_quant});
          m_busy = 1; m_ticks = 0;
        end else begin
          if (m_busy) begin
            if (m_ticks == SLOT_T - 1) m_busy = 0;
            else m_ticks++;
          end
          if (mq.size() > 0) begin
            {e_mode, e_data} = mq.pop_front(); e_tag = 3'd7;
          end else if (side_valid) begin
            e_mode = 4'hF; e_tag = side_tag; e_data = side_data;
          end else begin
            e_mode = 4'hF; e_tag = 3'd7; e_data = 8'h00;
          end
        end
      end
    end
  end

  // per-clock comparison and stream monitors
  int cyc = 0, last_ctrl = -1, fills_seen = 0;
  logic [3:0] prev_mode = 4'hF;

  function automatic string data_req(logic [3:0] md, logic [7:0] d);
    if (md == 4'h2) return d[0] ? "R6" : "R5";
    if (md == 4'h0 || md == 4'h1) return "R8";
    if (md == 4'h3) return "R3";
    return "R10";
  endfunction

  initial begin
    forever begin
      @(negedge clk); #1.5;
      if (rst_n && !done) begin
        int ng, nm;
        bit open, exp_rr, exp_sr;
        cyc++;
        open   = !m_busy || (m_ticks == SLOT_T - 1);
        succ(pg, pm, cif_mode, ng, nm);
        exp_rr = m_phase && open && rec_valid &&
                 (int'(rec_gob) == ng) && (int'(rec_mb) == nm);
        exp_sr = m_phase && side_valid && !(open && rec_valid) && (mq.size() == 0);
        chk(out_clk == m_phase, "R1", "out_clk", out_clk, m_phase);
        chk(out_mode == e_mode, "R2", "out_mode", out_mode, e_mode);
        chk(out_data == e_data, data_req(e_mode, e_data), "out_data", out_data, e_data);
        chk(out_tag == e_tag, "R10", "out_tag", out_tag, e_tag);
        chk(rec_ready == exp_rr, "R11", "rec_ready", rec_ready, exp_rr);
        chk(side_ready == exp_sr, "R10", "side_ready", side_ready, exp_sr);
        if (m_loaded) begin
          if (out_mode == 4'h0) chk(prev_mode == 4'h2, "R3", "mode before GOB", prev_mode, 2);
          if (out_mode == 4'h1) chk(prev_mode == 4'h0, "R3", "mode before MB", prev_mode, 0);
          if (out_mode == 4'h3) chk(prev_mode == 4'h1, "R3", "mode before quant", prev_mode, 1);
          if (out_mode == 4'h2) begin
            if (last_ctrl >= 0)
              chk(cyc - last_ctrl >= BSLOT, "R4", "ctrl spacing", cyc - last_ctrl, BSLOT);
            last_ctrl = cyc;
            if (out_data[0]) begin
              fills_seen++;
              chk(out_data[1] == 1'b0, "R6", "fixed is intra", out_data[1], 0);
            end
          end
          if (out_mode == 4'h0 && !cif_mode)
            chk(out_data == 1 || out_data == 3 || out_data == 5, "R8", "QCIF gob", out_data, 1);
          if (out_mode == 4'h1)
            chk(out_data >= 1 && out_data <= 33, "R8", "mb range", out_data, 33);
          prev_mode = out_mode;
        end
      end
    end
  end

  task automatic send(input int g, input int m, input logic [6:0] c,
                      input bit hq, input logic [7:0] q, input int exp_fills, input string req);
    int f0;
    f0 = fills_seen;
    @(negedge clk);
    rec_valid = 1; rec_gob = 4'(g); rec_mb = 6'(m); rec_ctrl = c;
    rec_has_quant = hq; rec_quant = q;
    forever begin
      #1.5;
      if (rec_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    rec_valid = 0;
    #2;
    chk(fills_seen - f0 == exp_fills, req, "fixed slots before record", fills_seen - f0, exp_fills);
  endtask

  // side-information source
  initial begin
    side_valid = 0; side_tag = 3'd0; side_data = 8'h00;
    @(posedge rst_n);
    for (int i = 0; i < 100000; i++) begin
      repeat ((i * 7) % 13) @(negedge clk);
      @(negedge clk);
      side_valid = 1; side_tag = 3'(i % 5); side_data = 8'(i * 3 + 1);
      forever begin
        #1.5;
        if (side_ready) break;
        @(negedge clk);
      end
      @(negedge clk);
      side_valid = 0;
    end
  end

  initial begin
    rst_n = 0; cif_mode = 0; rec_valid = 0; rec_gob = 0; rec_mb = 0;
    rec_ctrl = 0; rec_has_quant = 0; rec_quant = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    chk(out_mode == 4'hF, "R9", "reset mode", out_mode, 15);
    chk(out_tag == 3'd7, "R9", "reset tag", out_tag, 7);
    chk(out_data == 8'h00, "R9", "reset data", out_data, 0);
    // QCIF picture, with wrap through end of picture
    send(1, 1, 7'h0A, 1, 8'h1F, 0, "R9");
    send(3, 1, 7'h02, 0, 8'h00, 32, "R7");
    send(1, 3, 7'h0E, 1, 8'h05, 67, "R7");
    repeat (BSLOT) @(negedge clk);
    cif_mode = 1;
    // CIF numbering
    send(1, 4, 7'h0C, 1, 8'h11, 0, "R8");
    send(1, 5, 7'h06, 0, 8'h00, 0, "R5");
    send(1, 8, 7'h02, 1, 8'h1E, 2, "R7");
    send(3, 1, 7'h08, 0, 8'h00, 58, "R8");
    send(12, 32, 7'h04, 1, 8'h07, 327, "R8");
    send(1, 2, 7'h0A, 0, 8'h00, 2, "R7");
    repeat (3 * BSLOT) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule